// File: doc/BRIEF.md
# Ranked Three-of-Eighteen Candidate Sorter

Every clock period this block receives a set of track candidates from nine source links, with up to two candidates per link. Each candidate has a valid bit, a quality score and an opaque payload. The block finds the three strongest candidates and places them on three ranked output slots, strongest first. Each output slot is tagged with the link it came from (numbered from 1) and with the candidate's position inside that link. The block also returns a winner word that has one bit per link. A bit is set when that link placed at least one candidate in the three slots, so each source can learn whether it was chosen.

Ranking uses a strict total order. A valid candidate always outranks an invalid one. Within the valid candidates, higher quality ranks higher. When qualities are equal, the lower link number wins, and within one link the first candidate beats the second. The design is a fixed pipeline that accepts a new candidate set on every clock. An optional register between the comparison network and the rank selection trades one cycle of latency for a shorter logic path.

Top module: `trk_sort3`

## Requirements
- R1: Among valid candidates, output slot 0 carries the highest quality, slot 1 the next and slot 2 the third, so valid slots have non-increasing quality.
- R2: An invalid candidate never occupies an output slot, whatever its quality, while any valid candidate is left unselected.
- R3: On equal quality, the candidate from the lower link number ranks higher; on the same link, position 0 ranks above position 1.
- R4: When fewer than three candidates are valid, the valid slots are packed from slot 0 upward, and each unused slot has out_valid clear and its quality, payload, link and position fields all zero.
- R5: Candidate index i equals 2*(link-1)+pos. Its fields are in_valid[i], in_qual[i*4 +: 4] and in_pay[i*8 +: 8]. Slot s reports out_link[s*4 +: 4] = link (1 to 9) and out_pos[s] = pos, together with that candidate's quality and payload.
- R6: winner[k-1] is 1 exactly when some valid output slot carries a candidate from link k.
- R7: A candidate set presented before clock edge n appears on the outputs after edge n+2 (default configuration with the compare register). A new set is accepted on every clock.
- R8: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 18 | Valid bit per candidate, index 2*(link-1)+pos |
| in_qual | input | 72 | 4-bit quality per candidate |
| in_pay | input | 144 | 8-bit payload per candidate |
| out_valid | output | 3 | Slot valid, slot 0 strongest |
| out_qual | output | 12 | Quality per slot |
| out_pay | output | 24 | Payload per slot |
| out_link | output | 12 | Source link number 1..9 per slot |
| out_pos | output | 3 | Position within source link per slot |
| winner | output | 9 | Per-link selection flag, bit k-1 for link k |

## Verification
A corrupted comparison or rank count shows up at the ports in the same output cycle as the set that triggered it. It appears as a slot holding lower quality than the slot after it, as a tie resolved toward the higher link, or as a winner bit that disagrees with the reported links. A stale or misaligned pipeline register shows up as outputs that belong to the neighbouring candidate set. Back-to-back distinct sets expose this on the first cycle after the fault. Sparse sets catch packing errors and unused slots that are not zeroed, because valid slots must be contiguous from slot 0 and empty ones must read zero.

// File: rtl/t3s_pkg.sv
package t3s_pkg;

   // Selects whether the pairwise comparison results are registered
   typedef enum logic {
      CMP_COMB = 1'b0,
      CMP_REG  = 1'b1
   } cmp_stage_e;

   // Bits needed to hold values 0..n-1 (at least one bit)
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/t3s_in_reg.sv
module t3s_in_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("t3s_in_reg: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/t3s_beat_matrix.sv
module t3s_beat_matrix #(
   parameter int N_CAND  = 18,
   parameter int QUAL_W  = 4,
   parameter int PAY_W   = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int IW     = t3s_pkg::idx_bits(N_CAND),
   localparam int KW     = 1 + QUAL_W + IW
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_CAND-1:0]         c_valid,
   input  logic [N_CAND*QUAL_W-1:0]  c_qual,
   input  logic [N_CAND*PAY_W-1:0]   c_pay,
   output logic [N_CAND*N_CAND-1:0]  o_beats,
   output logic [N_CAND-1:0]         o_valid,
   output logic [N_CAND*QUAL_W-1:0]  o_qual,
   output logic [N_CAND*PAY_W-1:0]   o_pay
);

   // Unique key per candidate: valid, quality, inverted index (lower index wins ties)
   logic [KW-1:0]            key [N_CAND];
   logic [N_CAND*N_CAND-1:0] beats_c;

   always_comb begin
      for (int i = 0; i < N_CAND; i++) begin
         key[i] = {c_valid[i], c_qual[i*QUAL_W +: QUAL_W], ~IW'(i)};
      end
   end

   // beats_c[j*N_CAND+i] = candidate j outranks candidate i
   always_comb begin
      beats_c = '0;
      for (int j = 0; j < N_CAND; j++) begin
         for (int i = j + 1; i < N_CAND; i++) begin
            beats_c[j*N_CAND+i] = key[j] > key[i];
            beats_c[i*N_CAND+j] = ~(key[j] > key[i]);
         end
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            o_beats <= '0;
            o_valid <= '0;
            o_qual  <= '0;
            o_pay   <= '0;
         end else begin
            o_beats <= beats_c;
            o_valid <= c_valid;
            o_qual  <= c_qual;
            o_pay   <= c_pay;
         end
      end
   end else begin : g_comb
      assign o_beats = beats_c;
      assign o_valid = c_valid;
      assign o_qual  = c_qual;
      assign o_pay   = c_pay;
   end

endmodule

// File: rtl/t3s_rank_select.sv
module t3s_rank_select #(
   parameter int N_LINKS = 9,
   parameter int N_CAND  = 18,
   parameter int N_OUT   = 3,
   parameter int QUAL_W  = 4,
   parameter int PAY_W   = 8,
   parameter int LINK_W  = 4,
   parameter int POS_W   = 1,
   localparam int CPL    = N_CAND / N_LINKS,
   localparam int RW     = $clog2(N_CAND + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_CAND*N_CAND-1:0]  beats,
   input  logic [N_CAND-1:0]         c_valid,
   input  logic [N_CAND*QUAL_W-1:0]  c_qual,
   input  logic [N_CAND*PAY_W-1:0]   c_pay,
   output logic [N_OUT-1:0]          out_valid,
   output logic [N_OUT*QUAL_W-1:0]   out_qual,
   output logic [N_OUT*PAY_W-1:0]    out_pay,
   output logic [N_OUT*LINK_W-1:0]   out_link,
   output logic [N_OUT*POS_W-1:0]    out_pos,
   output logic [N_LINKS-1:0]        winner
);

   logic [RW-1:0]     rank [N_CAND];
   logic [N_CAND-1:0] pick [N_OUT];

   logic [N_OUT-1:0]        nx_valid;
   logic [N_OUT*QUAL_W-1:0] nx_qual;
   logic [N_OUT*PAY_W-1:0]  nx_pay;
   logic [N_OUT*LINK_W-1:0] nx_link;
   logic [N_OUT*POS_W-1:0]  nx_pos;
   logic [N_LINKS-1:0]      nx_win;

   // Rank of a candidate = number of candidates that outrank it
   always_comb begin
      for (int i = 0; i < N_CAND; i++) begin
         rank[i] = '0;
         for (int j = 0; j < N_CAND; j++) begin
            rank[i] = rank[i] + RW'(beats[j*N_CAND+i]);
         end
      end
   end

   // Slot s holds the valid candidate whose rank equals s
   always_comb begin
      for (int s = 0; s < N_OUT; s++) begin
         for (int i = 0; i < N_CAND; i++) begin
            pick[s][i] = c_valid[i] && (rank[i] == RW'(s));
         end
      end
   end

   always_comb begin
      nx_valid = '0;
      nx_qual  = '0;
      nx_pay   = '0;
      nx_link  = '0;
      nx_pos   = '0;
      nx_win   = '0;
      for (int s = 0; s < N_OUT; s++) begin
         for (int i = 0; i < N_CAND; i++) begin
            if (pick[s][i]) begin
               nx_valid[s] = 1'b1;
               nx_qual[s*QUAL_W +: QUAL_W] = nx_qual[s*QUAL_W +: QUAL_W] | c_qual[i*QUAL_W +: QUAL_W];
               nx_pay[s*PAY_W +: PAY_W]    = nx_pay[s*PAY_W +: PAY_W] | c_pay[i*PAY_W +: PAY_W];
               nx_link[s*LINK_W +: LINK_W] = nx_link[s*LINK_W +: LINK_W] | LINK_W'(i / CPL + 1);
               nx_pos[s*POS_W +: POS_W]    = nx_pos[s*POS_W +: POS_W] | POS_W'(i % CPL);
               nx_win[i / CPL]             = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= '0;
         out_qual  <= '0;
         out_pay   <= '0;
         out_link  <= '0;
         out_pos   <= '0;
         winner    <= '0;
      end else begin
         out_valid <= nx_valid;
         out_qual  <= nx_qual;
         out_pay   <= nx_pay;
         out_link  <= nx_link;
         out_pos   <= nx_pos;
         winner    <= nx_win;
      end
   end

endmodule

// File: rtl/trk_sort3.sv
module trk_sort3 #(
   parameter int N_LINKS                 = 9,
   parameter int CANDS_PER_LINK          = 2,
   parameter int N_OUT                   = 3,
   parameter int QUAL_W                  = 4,
   parameter int PAY_W                   = 8,
   parameter int LINK_W                  = 4,
   parameter t3s_pkg::cmp_stage_e CMP_STAGE = t3s_pkg::CMP_REG,
   localparam int N_CAND  = N_LINKS * CANDS_PER_LINK,
   localparam int POS_W   = t3s_pkg::idx_bits(CANDS_PER_LINK),
   localparam int LATENCY = (CMP_STAGE == t3s_pkg::CMP_REG) ? 3 : 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_CAND-1:0]         in_valid,
   input  logic [N_CAND*QUAL_W-1:0]  in_qual,
   input  logic [N_CAND*PAY_W-1:0]   in_pay,
   output logic [N_OUT-1:0]          out_valid,
   output logic [N_OUT*QUAL_W-1:0]   out_qual,
   output logic [N_OUT*PAY_W-1:0]    out_pay,
   output logic [N_OUT*LINK_W-1:0]   out_link,
   output logic [N_OUT*POS_W-1:0]    out_pos,
   output logic [N_LINKS-1:0]        winner
);

   localparam int IN_W = N_CAND * (1 + QUAL_W + PAY_W);

   // Elaboration-time parameter checks
   if (N_LINKS < 1 || CANDS_PER_LINK < 1) begin : g_bad_links
      $error("trk_sort3: need at least one link and one candidate per link");
   end
   if (N_OUT < 1 || N_OUT > N_CAND) begin : g_bad_out
      $error("trk_sort3: N_OUT must be between 1 and the candidate count");
   end
   if ((1 << LINK_W) <= N_LINKS) begin : g_bad_linkw
      $error("trk_sort3: LINK_W too narrow for link numbers 1..N_LINKS");
   end
   if (QUAL_W < 1 || PAY_W < 1) begin : g_bad_fields
      $error("trk_sort3: field widths must be positive");
   end

   logic [N_CAND-1:0]        r_valid;
   logic [N_CAND*QUAL_W-1:0] r_qual;
   logic [N_CAND*PAY_W-1:0]  r_pay;

   t3s_in_reg #(.W(IN_W)) u_in (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({in_valid, in_qual, in_pay}),
      .q     ({r_valid, r_qual, r_pay})
   );

   logic [N_CAND*N_CAND-1:0] m_beats;
   logic [N_CAND-1:0]        m_valid;
   logic [N_CAND*QUAL_W-1:0] m_qual;
   logic [N_CAND*PAY_W-1:0]  m_pay;

   t3s_beat_matrix #(
      .N_CAND  (N_CAND),
      .QUAL_W  (QUAL_W),
      .PAY_W   (PAY_W),
      .REG_OUT (CMP_STAGE == t3s_pkg::CMP_REG)
   ) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .c_valid (r_valid),
      .c_qual  (r_qual),
      .c_pay   (r_pay),
      .o_beats (m_beats),
      .o_valid (m_valid),
      .o_qual  (m_qual),
      .o_pay   (m_pay)
   );

   t3s_rank_select #(
      .N_LINKS (N_LINKS),
      .N_CAND  (N_CAND),
      .N_OUT   (N_OUT),
      .QUAL_W  (QUAL_W),
      .PAY_W   (PAY_W),
      .LINK_W  (LINK_W),
      .POS_W   (POS_W)
   ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .beats     (m_beats),
      .c_valid   (m_valid),
      .c_qual    (m_qual),
      .c_pay     (m_pay),
      .out_valid (out_valid),
      .out_qual  (out_qual),
      .out_pay   (out_pay),
      .out_link  (out_link),
      .out_pos   (out_pos),
      .winner    (winner)
   );

endmodule

// File: rtl/trk_sort3_chk.sv
module trk_sort3_chk #(
   parameter int N_LINKS = 9,
   parameter int N_CAND  = 18,
   parameter int N_OUT   = 3,
   parameter int QUAL_W  = 4,
   parameter int PAY_W   = 8,
   parameter int LINK_W  = 4,
   parameter int POS_W   = 1,
   parameter int LATENCY = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [N_CAND-1:0]        in_valid,
   input logic [N_OUT-1:0]         out_valid,
   input logic [N_OUT*QUAL_W-1:0]  out_qual,
   input logic [N_OUT*PAY_W-1:0]   out_pay,
   input logic [N_OUT*LINK_W-1:0]  out_link,
   input logic [N_OUT*POS_W-1:0]   out_pos,
   input logic [N_LINKS-1:0]       winner
);

   // Cycles since reset release, saturating at LATENCY
   logic [3:0] seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    seen <= '0;
      else if (seen < 4'(LATENCY))   seen <= seen + 4'd1;
   end

   for (genvar s = 0; s < N_OUT; s++) begin : g_slot
      // R4: empty slots read zero
      p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid[s] |-> (out_qual[s*QUAL_W +: QUAL_W] == '0 && out_pay[s*PAY_W +: PAY_W] == '0
                            && out_link[s*LINK_W +: LINK_W] == '0 && out_pos[s*POS_W +: POS_W] == '0));
      // R5: link number in range
      p_link_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[s] |-> (out_link[s*LINK_W +: LINK_W] >= LINK_W'(1)
                           && out_link[s*LINK_W +: LINK_W] <= LINK_W'(N_LINKS)));
      // R6: reported link is flagged as a winner
      p_winner_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[s] |-> |(winner & (N_LINKS'(1) << (out_link[s*LINK_W +: LINK_W] - LINK_W'(1)))));
      if (s > 0) begin : g_pair
         // R1: non-increasing quality across valid slots
         p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[s] |-> (out_qual[(s-1)*QUAL_W +: QUAL_W] >= out_qual[s*QUAL_W +: QUAL_W]));
         // R4: valid slots are packed from slot 0
         p_pack_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[s] |-> out_valid[s-1]);
         // R3: ties resolved toward lower link, then lower position
         p_tie_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[s] && out_qual[(s-1)*QUAL_W +: QUAL_W] == out_qual[s*QUAL_W +: QUAL_W])
            |-> ((out_link[(s-1)*LINK_W +: LINK_W] < out_link[s*LINK_W +: LINK_W])
                 || (out_link[(s-1)*LINK_W +: LINK_W] == out_link[s*LINK_W +: LINK_W]
                     && out_pos[(s-1)*POS_W +: POS_W] < out_pos[s*POS_W +: POS_W])));
      end
   end

   // R6: no more flagged links than valid slots, and any flag implies slot 0 valid
   p_winner_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(winner) <= $countones(out_valid)) && ((|winner) == out_valid[0]));

   // R7: slot 0 valid exactly when the set presented LATENCY cycles ago had a valid candidate
   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen >= 4'(LATENCY)) |-> (out_valid[0] == $past(|in_valid, LATENCY)));

endmodule

bind trk_sort3 trk_sort3_chk #(
   .N_LINKS (N_LINKS),
   .N_CAND  (N_CAND),
   .N_OUT   (N_OUT),
   .QUAL_W  (QUAL_W),
   .PAY_W   (PAY_W),
   .LINK_W  (LINK_W),
   .POS_W   (POS_W),
   .LATENCY (LATENCY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_qual  (out_qual),
   .out_pay   (out_pay),
   .out_link  (out_link),
   .out_pos   (out_pos),
   .winner    (winner)
);

// File: tb/trk_sort3_tb_top.sv
module trk_sort3_tb_top;

   localparam int NL  = 9;
   localparam int NC  = 18;
   localparam int NO  = 3;
   localparam int QW  = 4;
   localparam int PW  = 8;
   localparam int LW  = 4;
   localparam int PSW = 1;
   localparam int LAT = 3;
   localparam int EW  = NO + NO*QW + NO*PW + NO*LW + NO*PSW + NL;
   localparam int MAXV = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic              rst_n;
   logic [NC-1:0]     in_valid;
   logic [NC*QW-1:0]  in_qual;
   logic [NC*PW-1:0]  in_pay;
   logic [NO-1:0]     out_valid;
   logic [NO*QW-1:0]  out_qual;
   logic [NO*PW-1:0]  out_pay;
   logic [NO*LW-1:0]  out_link;
   logic [NO*PSW-1:0] out_pos;
   logic [NL-1:0]     winner;

   trk_sort3 dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_qual   (in_qual),
      .in_pay    (in_pay),
      .out_valid (out_valid),
      .out_qual  (out_qual),
      .out_pay   (out_pay),
      .out_link  (out_link),
      .out_pos   (out_pos),
      .winner    (winner)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [NC-1:0]    sv [MAXV];
   logic [NC*QW-1:0] sq [MAXV];
   logic [NC*PW-1:0] sp [MAXV];
   int nvec;

   function automatic logic [EW-1:0] actual();
      return {out_valid, out_qual, out_pay, out_link, out_pos, winner};
   endfunction

   // Reference: repeatedly take the strongest unused valid candidate, scanning
   // from the lowest index so that equal quality keeps the lower index
   function automatic logic [EW-1:0] model(input logic [NC-1:0] v, input logic [NC*QW-1:0] q,
                                           input logic [NC*PW-1:0] p);
      logic [NC-1:0]     used;
      logic [NO-1:0]     ev;
      logic [NO*QW-1:0]  eq;
      logic [NO*PW-1:0]  ep;
      logic [NO*LW-1:0]  el;
      logic [NO*PSW-1:0] eo;
      logic [NL-1:0]     ew;
      used = '0; ev = '0; eq = '0; ep = '0; el = '0; eo = '0; ew = '0;
      for (int s = 0; s < NO; s++) begin
         int best;
         best = -1;
         for (int i = 0; i < NC; i++) begin
            if (v[i] && !used[i]) begin
               if (best < 0) best = i;
               else if (q[i*QW +: QW] > q[best*QW +: QW]) best = i;
            end
         end
         if (best >= 0) begin
            used[best]        = 1'b1;
            ev[s]             = 1'b1;
            eq[s*QW +: QW]    = q[best*QW +: QW];
            ep[s*PW +: PW]    = p[best*PW +: PW];
            el[s*LW +: LW]    = LW'(best / 2 + 1);
            eo[s]             = 1'(best % 2);
            ew[best / 2]      = 1'b1;
         end
      end
      return {ev, eq, ep, el, eo, ew};
   endfunction

   task automatic check(input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive stored sets back to back, one per cycle, and compare each result LAT cycles later
   task automatic run_seq(input string req);
      for (int c = 0; c < nvec + LAT; c++) begin
         @(negedge clk);
         if (c >= LAT) check(req, actual(), model(sv[c-LAT], sq[c-LAT], sp[c-LAT]));
         if (c < nvec) begin
            in_valid = sv[c]; in_qual = sq[c]; in_pay = sp[c];
         end else begin
            in_valid = '0; in_qual = '0; in_pay = '0;
         end
      end
      @(negedge clk);
      check(req, actual(), model('0, '0, '0));
   endtask

   task automatic fill_random(input int k, input int vmask_mode);
      for (int i = 0; i < NC; i++) begin
         sq[k][i*QW +: QW] = QW'($urandom_range(0, 15));
         sp[k][i*PW +: PW] = PW'($urandom_range(0, 255));
         sv[k][i] = (vmask_mode == 0) ? 1'b1 : 1'($urandom_range(0, 3) == 0);
      end
   endtask

   // R8: outputs held at zero during reset
   task automatic t_reset();
      rst_n = 1'b0;
      in_valid = '1; in_qual = '1; in_pay = '1;
      repeat (3) @(negedge clk);
      check("R8", actual(), '0);
      in_valid = '0; in_qual = '0; in_pay = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8", actual(), '0);
   endtask

   // R1, R5, R6: fully populated sets with random qualities and payloads
   task automatic t_full_random();
      nvec = 4;
      for (int k = 0; k < nvec; k++) fill_random(k, 0);
      run_seq("R1");
      // distinct qualities placed on known links, checked for link/pos/winner
      nvec = 1;
      sv[0] = '0; sq[0] = '0; sp[0] = '0;
      sv[0][13] = 1'b1; sq[0][13*QW +: QW] = 4'd9;  sp[0][13*PW +: PW] = 8'hA1;
      sv[0][4]  = 1'b1; sq[0][4*QW +: QW]  = 4'd12; sp[0][4*PW +: PW]  = 8'hB2;
      sv[0][17] = 1'b1; sq[0][17*QW +: QW] = 4'd3;  sp[0][17*PW +: PW] = 8'hC3;
      sv[0][0]  = 1'b1; sq[0][0*QW +: QW]  = 4'd1;  sp[0][0*PW +: PW]  = 8'hD4;
      run_seq("R5");
      run_seq("R6");
   endtask

   // R2: invalid candidates carry top quality and must lose
   task automatic t_invalid_strong();
      nvec = 2;
      for (int k = 0; k < nvec; k++) begin
         for (int i = 0; i < NC; i++) begin
            sv[k][i] = (i % 3 == k);
            sq[k][i*QW +: QW] = sv[k][i] ? QW'(i % 5) : 4'd15;
            sp[k][i*PW +: PW] = PW'(i * 7 + k);
         end
      end
      run_seq("R2");
   endtask

   // R3: equal quality everywhere, and mixed ties across and within links
   task automatic t_ties();
      nvec = 3;
      sv[0] = '1; sq[0] = {NC{4'd6}};
      for (int i = 0; i < NC; i++) sp[0][i*PW +: PW] = PW'(i + 8'h40);
      sv[1] = '0; sq[1] = '0; sp[1] = '0;
      sv[1][9]  = 1'b1; sq[1][9*QW +: QW]  = 4'd7; sp[1][9*PW +: PW]  = 8'h19;
      sv[1][8]  = 1'b1; sq[1][8*QW +: QW]  = 4'd7; sp[1][8*PW +: PW]  = 8'h18;
      sv[1][15] = 1'b1; sq[1][15*QW +: QW] = 4'd7; sp[1][15*PW +: PW] = 8'h1F;
      sv[1][3]  = 1'b1; sq[1][3*QW +: QW]  = 4'd7; sp[1][3*PW +: PW]  = 8'h13;
      sv[2] = '0; sq[2] = '0; sp[2] = '0;
      sv[2][11] = 1'b1; sq[2][11*QW +: QW] = 4'd2; sp[2][11*PW +: PW] = 8'h2B;
      sv[2][10] = 1'b1; sq[2][10*QW +: QW] = 4'd2; sp[2][10*PW +: PW] = 8'h2A;
      sv[2][16] = 1'b1; sq[2][16*QW +: QW] = 4'd5; sp[2][16*PW +: PW] = 8'h30;
      run_seq("R3");
   endtask

   // R4: zero, one and two valid candidates
   task automatic t_sparse();
      nvec = 3;
      sv[0] = '0; sq[0] = '1; sp[0] = '1;
      sv[1] = '0; sq[1] = '1; sp[1] = '1; sv[1][7] = 1'b1;
      sv[2] = '0; sq[2] = '1; sp[2] = '1; sv[2][2] = 1'b1; sv[2][12] = 1'b1;
      sq[2][12*QW +: QW] = 4'd4;
      run_seq("R4");
   endtask

   // R7: long back-to-back stream of sparse random sets
   task automatic t_stream();
      nvec = MAXV;
      for (int k = 0; k < nvec; k++) fill_random(k, 1);
      run_seq("R7");
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      in_valid = '0; in_qual = '0; in_pay = '0; rst_n = 1'b0;
      t_reset();
      t_full_random();
      t_invalid_strong();
      t_ties();
      t_sparse();
      t_stream();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R7 watchdog actual=hung expected=complete");
         summary();
         $finish;
      end
   end

endmodule